// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block turns a 16-bit pointer, built from a high and a low register byte, into an effective memory address for loads and stores. It also produces the updated pointer value and a write-back enable for the register file. Data-memory accesses support four addressing modes: plain, pre-decrement, post-increment, and unsigned displacement. Program-memory byte loads come in two forms. The short form addresses through the pointer alone. The extended form prefixes the pointer with an 8-bit page register, which gives a 24-bit address; in that case a post-increment carries from the pointer into the page.

A request is presented for one cycle with `req_valid` high. All results appear registered on the following clock edge, qualified by `rsp_valid`. Program loads accept only the plain and post-increment modes. Any other mode raises `mode_err` and blocks every write-back. For an extended load whose address lies at or beyond the program-memory size, `fill_ones` is raised, and the reader substitutes 0xFF for the fetched byte. The memories and the register file sit outside this block.

Top module: `ptr_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `ptr_wr_en`, `page_wr_en`, `mode_err` and `fill_ones` are 0.
- R2: Plain mode (`mode`=0) on a data access (`op`=0 load, `op`=1 store) gives `eff_addr` = {ptr_hi, ptr_lo}, zero-extended, with `ptr_wr_en`=0.
- R3: Pre-decrement mode (`mode`=1) on a data access gives `eff_addr` = pointer − 1, `ptr_wr_en`=1, and a new pointer equal to that same address.
- R4: Post-increment mode (`mode`=2) on a data access gives `eff_addr` = the original pointer, `ptr_wr_en`=1, and a new pointer equal to pointer + 1.
- R5: Displacement mode (`mode`=3) on a data access gives `eff_addr` = pointer + the unsigned 6-bit `disp`, with `ptr_wr_en`=0.
- R6: All 16-bit pointer arithmetic wraps modulo 2^16. Examples: 0x0000 pre-decremented gives 0xFFFF, 0xFFFF post-incremented gives 0x0000, and 0xFFF0 + 0x3F gives 0x002F.
- R7: A short program load (`op`=2) gives `eff_addr` = pointer with the upper 8 bits zero. Post-increment writes back pointer + 1, wrapping in 16 bits, with `page_wr_en`=0.
- R8: An extended program load (`op`=3) gives `eff_addr` = {page, pointer}. Post-increment writes back the 24-bit sum {page, pointer} + 1 split into a new pointer and a new page, with `ptr_wr_en`=1 and `page_wr_en`=1.
- R9: A program load (`op` 2 or 3) in pre-decrement or displacement mode raises `mode_err`, with `ptr_wr_en`=0 and `page_wr_en`=0.
- R10: An extended program load whose 24-bit address is at least `PROG_BYTES` raises `fill_ones`. Below that limit, and for any other operation, `fill_ones` is 0.
- R11: `rsp_valid` follows `req_valid` by exactly one cycle. When no request was presented, all enables and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request presented this cycle |
| op | input | 2 | 0 data load, 1 data store, 2 short program load, 3 extended program load |
| mode | input | 2 | 0 plain, 1 pre-decrement, 2 post-increment, 3 displacement |
| ptr_hi | input | 8 | High byte of pointer pair (odd register) |
| ptr_lo | input | 8 | Low byte of pointer pair (even register) |
| disp | input | 6 | Unsigned displacement |
| page | input | 8 | Page register for the extended program load |
| rsp_valid | output | 1 | Results valid |
| eff_addr | output | 24 | Effective address |
| ptr_wr_en | output | 1 | Write pointer pair back |
| ptr_new_hi | output | 8 | New high pointer byte |
| ptr_new_lo | output | 8 | New low pointer byte |
| page_wr_en | output | 1 | Write page register back |
| page_new | output | 8 | New page value |
| mode_err | output | 1 | Illegal mode on a program load |
| fill_ones | output | 1 | Extended load beyond program memory; byte reads as 0xFF |

## Verification
The bench builds the block with `PROG_BYTES` = 0x010100, which places the end of program memory just above page 1, offset 0x0100. With that limit, the addresses 0x0100FF and 0x010100 form a pair on either side of the boundary, and both can be reached with small page values. The same build also exercises the pointer carry into the page: post-incrementing page 0, offset 0xFFFF produces page 1, offset 0x0000.

// File: rtl/ptr_agu_pkg.sv
// Shared encodings for the pointer address generator.
package ptr_agu_pkg;
    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_PREDEC  = 2'd1,
        AM_POSTINC = 2'd2,
        AM_OFFSET  = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        OP_DLOAD  = 2'd0,
        OP_DSTORE = 2'd1,
        OP_PLOAD  = 2'd2,
        OP_XLOAD  = 2'd3
    } aop_e;
endpackage

// File: rtl/ptr_data_agu.sv
// Data-memory address path. Computes the effective address and the pointer
// write-back for the four data addressing modes. Purely combinational;
// all arithmetic wraps in PTR_W bits. Assumes the displacement is unsigned.
module ptr_data_agu
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DISP_W = 6
) (
    input  amode_e             mode,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [DISP_W-1:0]  disp,
    output logic [PTR_W-1:0]   addr,
    output logic               wb_en,
    output logic [PTR_W-1:0]   wb_ptr
);
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_off;

    // Candidate results for every mode, all modulo 2^PTR_W.
    always_comb begin
        ptr_dec = ptr - PTR_W'(1);
        ptr_inc = ptr + PTR_W'(1);
        ptr_off = ptr + PTR_W'(disp);
    end

    // Mode select for address and write-back.
    always_comb begin
        addr   = ptr;
        wb_en  = 1'b0;
        wb_ptr = ptr;
        unique case (mode)
            AM_PLAIN:   addr = ptr;
            AM_PREDEC: begin
                addr   = ptr_dec;
                wb_en  = 1'b1;
                wb_ptr = ptr_dec;
            end
            AM_POSTINC: begin
                addr   = ptr;
                wb_en  = 1'b1;
                wb_ptr = ptr_inc;
            end
            AM_OFFSET:  addr = ptr_off;
            default:    addr = ptr;
        endcase
    end
endmodule

// File: rtl/ptr_prog_agu.sv
// Program-memory byte-load address path. Handles the short form (pointer
// only) and the extended form ({page, pointer}). Only the plain and
// post-increment modes are legal; others flag an error and suppress
// write-back. The end-of-memory check is built only when PROG_BYTES
// does not cover the whole extended address space.
module ptr_prog_agu
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W      = 16,
    parameter int PAGE_W     = 8,
    parameter int PROG_BYTES = 24'h030000
) (
    input  logic                      ext,
    input  amode_e                    mode,
    input  logic [PTR_W-1:0]          ptr,
    input  logic [PAGE_W-1:0]         page,
    output logic [PTR_W+PAGE_W-1:0]   addr,
    output logic                      wb_en,
    output logic [PTR_W-1:0]          wb_ptr,
    output logic                      page_wb_en,
    output logic [PAGE_W-1:0]         page_wb,
    output logic                      err,
    output logic                      beyond
);
    localparam int ADDR_W = PTR_W + PAGE_W;

    logic [ADDR_W-1:0] wide_inc;
    logic              legal;
    logic              is_inc;

    // Address formation and 24-bit increment.
    always_comb begin
        addr     = ext ? {page, ptr} : {{PAGE_W{1'b0}}, ptr};
        wide_inc = {page, ptr} + ADDR_W'(1);
        legal    = (mode == AM_PLAIN) || (mode == AM_POSTINC);
        is_inc   = (mode == AM_POSTINC);
    end

    // Write-back: the extended form carries into the page, the short form wraps.
    always_comb begin
        err        = !legal;
        wb_en      = legal && is_inc;
        page_wb_en = legal && is_inc && ext;
        wb_ptr     = ext ? wide_inc[PTR_W-1:0] : ptr + PTR_W'(1);
        page_wb    = ext ? wide_inc[ADDR_W-1:PTR_W] : page;
    end

    generate
        if (longint'(PROG_BYTES) >= (longint'(1) << ADDR_W)) begin : g_no_limit
            // Program memory spans the full space: never beyond the end.
            always_comb beyond = 1'b0;
        end else begin : g_limit
            localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(PROG_BYTES);
            // Flag extended reads at or past the end of program memory.
            always_comb beyond = ext && legal && ({1'b0, addr} >= LIMIT);
        end
    endgenerate
endmodule

// File: rtl/ptr_addr_gen.sv
// Top of the pointer address generator. Assembles the pointer from its
// high/low register bytes, dispatches to the data or program path by
// operation, and registers all results one cycle after the request.
// Assumes callers apply the write-backs to the register file themselves.
module ptr_addr_gen
    import ptr_agu_pkg::*;
#(
    parameter int REG_W      = 8,
    parameter int PAGE_W     = 8,
    parameter int DISP_W     = 6,
    parameter int PROG_BYTES = 24'h030000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  op,
    input  logic [1:0]                  mode,
    input  logic [REG_W-1:0]            ptr_hi,
    input  logic [REG_W-1:0]            ptr_lo,
    input  logic [DISP_W-1:0]           disp,
    input  logic [PAGE_W-1:0]           page,
    output logic                        rsp_valid,
    output logic [2*REG_W+PAGE_W-1:0]   eff_addr,
    output logic                        ptr_wr_en,
    output logic [REG_W-1:0]            ptr_new_hi,
    output logic [REG_W-1:0]            ptr_new_lo,
    output logic                        page_wr_en,
    output logic [PAGE_W-1:0]           page_new,
    output logic                        mode_err,
    output logic                        fill_ones
);
    localparam int PTR_W  = 2 * REG_W;
    localparam int ADDR_W = PTR_W + PAGE_W;

    aop_e             op_e;
    amode_e           mode_e;
    logic [PTR_W-1:0] ptr;

    logic [PTR_W-1:0]  d_addr, d_wb_ptr;
    logic              d_wb_en;
    logic [ADDR_W-1:0] p_addr;
    logic [PTR_W-1:0]  p_wb_ptr;
    logic              p_wb_en, p_page_en, p_err, p_beyond;
    logic [PAGE_W-1:0] p_page;

    // Decode inputs and form the pointer pair.
    always_comb begin
        op_e   = aop_e'(op);
        mode_e = amode_e'(mode);
        ptr    = {ptr_hi, ptr_lo};
    end

    ptr_data_agu #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_data (
        .mode   (mode_e),
        .ptr    (ptr),
        .disp   (disp),
        .addr   (d_addr),
        .wb_en  (d_wb_en),
        .wb_ptr (d_wb_ptr)
    );

    ptr_prog_agu #(.PTR_W(PTR_W), .PAGE_W(PAGE_W), .PROG_BYTES(PROG_BYTES)) u_prog (
        .ext        (op_e == OP_XLOAD),
        .mode       (mode_e),
        .ptr        (ptr),
        .page       (page),
        .addr       (p_addr),
        .wb_en      (p_wb_en),
        .wb_ptr     (p_wb_ptr),
        .page_wb_en (p_page_en),
        .page_wb    (p_page),
        .err        (p_err),
        .beyond     (p_beyond)
    );

    logic              is_prog;
    logic [ADDR_W-1:0] n_addr;
    logic              n_wb_en;
    logic [PTR_W-1:0]  n_ptr;

    // Choose between the data and program paths.
    always_comb begin
        is_prog = (op_e == OP_PLOAD) || (op_e == OP_XLOAD);
        n_addr  = is_prog ? p_addr : ADDR_W'(d_addr);
        n_wb_en = is_prog ? p_wb_en : d_wb_en;
        n_ptr   = is_prog ? p_wb_ptr : d_wb_ptr;
    end

    // Register results; flags clear when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            eff_addr   <= '0;
            ptr_wr_en  <= 1'b0;
            ptr_new_hi <= '0;
            ptr_new_lo <= '0;
            page_wr_en <= 1'b0;
            page_new   <= '0;
            mode_err   <= 1'b0;
            fill_ones  <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            ptr_wr_en  <= req_valid && n_wb_en;
            page_wr_en <= req_valid && is_prog && p_page_en;
            mode_err   <= req_valid && is_prog && p_err;
            fill_ones  <= req_valid && is_prog && p_beyond;
            if (req_valid) begin
                eff_addr   <= n_addr;
                ptr_new_hi <= n_ptr[PTR_W-1:REG_W];
                ptr_new_lo <= n_ptr[REG_W-1:0];
                page_new   <= p_page;
            end
        end
    end
endmodule

// File: rtl/ptr_addr_gen_chk.sv
// Protocol and mode checks for ptr_addr_gen, attached through bind.
module ptr_addr_gen_chk #(
    parameter int REG_W      = 8,
    parameter int PAGE_W     = 8,
    parameter int DISP_W     = 6,
    parameter int PROG_BYTES = 24'h030000
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [1:0]                op,
    input logic [1:0]                mode,
    input logic [REG_W-1:0]          ptr_hi,
    input logic [REG_W-1:0]          ptr_lo,
    input logic                      rsp_valid,
    input logic [2*REG_W+PAGE_W-1:0] eff_addr,
    input logic                      ptr_wr_en,
    input logic                      page_wr_en,
    input logic                      mode_err,
    input logic                      fill_ones
);
    localparam int ADDR_W = 2 * REG_W + PAGE_W;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !ptr_wr_en && !page_wr_en && !mode_err && !fill_ones));

    // R9
    err_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!ptr_wr_en && !page_wr_en));

    // R8
    page_with_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr_en |-> ptr_wr_en);

    // R2
    no_wb_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op[1] && (mode == 2'd0 || mode == 2'd3)) |=> !ptr_wr_en);

    // R4
    postinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op[1] && mode == 2'd2) |=>
            (eff_addr == ADDR_W'($past({ptr_hi, ptr_lo})) && ptr_wr_en));

    // R10
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ones |-> ({1'b0, eff_addr} >= (ADDR_W+1)'(PROG_BYTES)));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(
    .REG_W(REG_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .PROG_BYTES(PROG_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .op         (op),
    .mode       (mode),
    .ptr_hi     (ptr_hi),
    .ptr_lo     (ptr_lo),
    .rsp_valid  (rsp_valid),
    .eff_addr   (eff_addr),
    .ptr_wr_en  (ptr_wr_en),
    .page_wr_en (page_wr_en),
    .mode_err   (mode_err),
    .fill_ones  (fill_ones)
);

// File: tb/ptr_addr_gen_test.sv
// Directed bench for ptr_addr_gen: one task per scenario.
module ptr_addr_gen_test;
    localparam int LIMIT = 24'h010100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  mode = '0;
    logic [7:0]  ptr_hi = '0, ptr_lo = '0, page = '0;
    logic [5:0]  disp = '0;
    logic        rsp_valid, ptr_wr_en, page_wr_en, mode_err, fill_ones;
    logic [23:0] eff_addr;
    logic [7:0]  ptr_new_hi, ptr_new_lo, page_new;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ptr_addr_gen #(.PROG_BYTES(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .mode(mode),
        .ptr_hi(ptr_hi), .ptr_lo(ptr_lo), .disp(disp), .page(page),
        .rsp_valid(rsp_valid), .eff_addr(eff_addr), .ptr_wr_en(ptr_wr_en),
        .ptr_new_hi(ptr_new_hi), .ptr_new_lo(ptr_new_lo), .page_wr_en(page_wr_en),
        .page_new(page_new), .mode_err(mode_err), .fill_ones(fill_ones)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request, then sample one cycle later away from the edge.
    task automatic issue(input logic [1:0] o, input logic [1:0] m, input logic [15:0] p,
                         input logic [5:0] d, input logic [7:0] pg);
        op = o; mode = m; ptr_hi = p[15:8]; ptr_lo = p[7:0]; disp = d; page = pg;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 enables", {ptr_wr_en, page_wr_en, mode_err, fill_ones}, 0);
    endtask

    task automatic t_plain();
        issue(0, 0, 16'h1234, 6'h3F, 8'h00);
        chk("R2 addr", eff_addr, 24'h001234);
        chk("R2 no wb", ptr_wr_en, 0);
        chk("R11 valid", rsp_valid, 1);
        issue(1, 0, 16'hBEEF, 0, 8'h05);
        chk("R2 store addr", eff_addr, 24'h00BEEF);
    endtask

    task automatic t_predec();
        issue(1, 1, 16'h0100, 0, 0);
        chk("R3 addr", eff_addr, 24'h0000FF);
        chk("R3 wb", {ptr_wr_en, ptr_new_hi, ptr_new_lo}, {1'b1, 16'h00FF});
    endtask

    task automatic t_postinc();
        issue(0, 2, 16'h20FF, 0, 0);
        chk("R4 addr", eff_addr, 24'h0020FF);
        chk("R4 wb", {ptr_wr_en, ptr_new_hi, ptr_new_lo}, {1'b1, 16'h2100});
        chk("R4 page untouched", page_wr_en, 0);
    endtask

    task automatic t_disp();
        issue(0, 3, 16'h1000, 6'h2A, 0);
        chk("R5 addr", eff_addr, 24'h00102A);
        chk("R5 no wb", ptr_wr_en, 0);
    endtask

    task automatic t_wrap();
        issue(0, 1, 16'h0000, 0, 0);
        chk("R6 predec wrap", {eff_addr, ptr_new_hi, ptr_new_lo}, {24'h00FFFF, 16'hFFFF});
        issue(1, 2, 16'hFFFF, 0, 0);
        chk("R6 postinc wrap", {ptr_new_hi, ptr_new_lo}, 16'h0000);
        issue(0, 3, 16'hFFF0, 6'h3F, 0);
        chk("R6 disp wrap", eff_addr, 24'h00002F);
    endtask

    task automatic t_short_prog();
        issue(2, 0, 16'h4321, 0, 8'h7F);
        chk("R7 addr", eff_addr, 24'h004321);
        chk("R7 plain no wb", {ptr_wr_en, page_wr_en}, 0);
        issue(2, 2, 16'hFFFF, 0, 8'h03);
        chk("R7 postinc", {eff_addr, ptr_wr_en, page_wr_en, ptr_new_hi, ptr_new_lo},
            {24'h00FFFF, 1'b1, 1'b0, 16'h0000});
    endtask

    task automatic t_ext_prog();
        issue(3, 0, 16'h00AB, 0, 8'h01);
        chk("R8 addr", eff_addr, 24'h0100AB);
        chk("R8 plain no wb", {ptr_wr_en, page_wr_en}, 0);
        issue(3, 2, 16'hFFFF, 0, 8'h00);
        chk("R8 carry", {ptr_wr_en, page_wr_en, page_new, ptr_new_hi, ptr_new_lo},
            {1'b1, 1'b1, 8'h01, 16'h0000});
        chk("R10 in range", fill_ones, 0);
    endtask

    task automatic t_illegal();
        issue(3, 1, 16'h0010, 0, 8'h00);
        chk("R9 ext predec", {mode_err, ptr_wr_en, page_wr_en}, 3'b100);
        issue(2, 3, 16'h0010, 6'h05, 8'h00);
        chk("R9 short disp", {mode_err, ptr_wr_en, page_wr_en}, 3'b100);
        issue(0, 1, 16'h0010, 0, 0);
        chk("R9 data no err", mode_err, 0);
    endtask

    task automatic t_beyond();
        issue(3, 0, 16'h00FF, 0, 8'h01);
        chk("R10 below limit", fill_ones, 0);
        issue(3, 2, 16'h0100, 0, 8'h01);
        chk("R10 at limit", fill_ones, 1);
        issue(3, 0, 16'h0000, 0, 8'hFF);
        chk("R10 far beyond", fill_ones, 1);
        issue(2, 0, 16'hFFFF, 0, 8'hFF);
        chk("R10 short load", fill_ones, 0);
    endtask

    task automatic t_idle();
        issue(0, 2, 16'h0042, 0, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R11 idle valid", rsp_valid, 0);
        chk("R11 idle enables", {ptr_wr_en, page_wr_en, mode_err, fill_ones}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_predec();
        t_postinc();
        t_disp();
        t_wrap();
        t_short_prog();
        t_ext_prog();
        t_illegal();
        t_beyond();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule